// File: doc/BRIEF.md
# SPI Configuration Command Target

This block is an SPI slave, sampled on a system clock, that behaves like the configuration port of a small programmable device. The host lowers chip select and clocks bytes in SPI mode 0: the bus idles low, data is sampled on the rising edge and shifted out on the falling edge, most significant bit first. Every transaction opens with a four-byte command. The first byte is the opcode. Commands can enable configuration, erase, load pages, mark programming complete, refresh, or read back a 32-bit identifier or status word.

Page loads carry sixteen data bytes. These go into an internal page memory at an address that advances by one after each load. Erase and refresh do not act at once: a busy flag stays set for a programmable number of system clock cycles first. A debug port reads any byte of the page memory combinationally. The done flag of the status word is also brought out on a pin.

Top module: `cfgt_target`

## Requirements
- R1: After reset the status word reads 0 except the device-version flag at bit 27, which equals the DEV_VER parameter, and the done output is 0.
- R2: Opcode 0xE0 returns the ID_WORD parameter and opcode 0x3C returns the status word. Either reply comes as transaction bytes 4 to 7, most significant byte first. Status layout: done bit 8, enable bit 9, busy bit 12, fail bit 13, error code bits 25:23, device version bit 27, all other bits 0.
- R3: Opcode 0xC6 with second byte 0x08 sets enable and clears fail and the error code. With any other second byte it sets the error code to 2 and leaves enable unchanged.
- R4: Opcode 0x0E holds busy for ERASE_CYCLES cycles, then clears busy and done and resets the page address to 0.
- R5: Opcode 0x70 followed by exactly 16 data bytes, while enabled, writes data byte k of the page at the current page address to debug index page*16+k. The address then advances, wrapping modulo PAGES.
- R6: A page load that ends with any count other than 16 data bytes sets the error code to 6, writes nothing and leaves the page address unchanged.
- R7: Opcode 0x70 or 0x5E received while not enabled sets the error code to 2 and sets fail, and writes nothing.
- R8: Opcode 0x5E while enabled sets done, clears the error code, and leaves busy at 0; the done output follows the done bit.
- R9: Opcode 0x46 resets the page address to 0.
- R10: Opcode 0x79 holds busy for REFRESH_CYCLES cycles, then clears enable and keeps done.
- R11: Any other opcode sets the error code to 2 and changes nothing else.
- R12: A transaction that ends before its fourth byte has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SPI bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low, frames a transaction |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host |
| dbg_addr | input | $clog2(PAGES*16) | Page memory byte index (page*16 + byte) |
| dbg_data | output | 8 | Page memory byte at dbg_addr |
| done | output | 1 | Copy of the status done bit |

## Verification
The status and ID replies are captured when the fourth command byte completes. Their bytes are then loaded one system cycle after each byte boundary, so the bench samples miso just before each rising sclk edge, a half SPI period after the shift. Commands act at the fourth byte, and a page write lands about four system cycles after chip select rises (three synchronizer stages plus one register). The bench therefore leaves 20 cycles after each frame before reading the debug port or starting the next status read. The busy windows are counted in system cycles from the fourth byte. The bench reads status within one transaction of the start, while busy must still be set, and again well after the window has closed.

// File: rtl/cfgt_pkg.sv
package cfgt_pkg;
    localparam logic [7:0] OP_READ_ID  = 8'hE0;
    localparam logic [7:0] OP_ENABLE   = 8'hC6;
    localparam logic [7:0] OP_ERASE    = 8'h0E;
    localparam logic [7:0] OP_FINISH   = 8'h5E;
    localparam logic [7:0] OP_ADDR_CLR = 8'h46;
    localparam logic [7:0] OP_PAGE     = 8'h70;
    localparam logic [7:0] OP_STATUS   = 8'h3C;
    localparam logic [7:0] OP_REFRESH  = 8'h79;
    localparam logic [7:0] ENABLE_KEY  = 8'h08;

    localparam logic [2:0] ERR_NONE = 3'd0;
    localparam logic [2:0] ERR_CMD  = 3'd2;
    localparam logic [2:0] ERR_OVFL = 3'd6;

    localparam int PAGE_BYTES = 16;

    typedef enum logic {WAIT_ERASE, WAIT_REFRESH} wait_kind_e;

    function automatic logic [31:0] pack_status(input logic dver, input logic [2:0] err,
                                                input logic fail, input logic busy,
                                                input logic en, input logic done_f);
        logic [31:0] w;
        w        = '0;
        w[27]    = dver;
        w[25:23] = err;
        w[13]    = fail;
        w[12]    = busy;
        w[9]     = en;
        w[8]     = done_f;
        return w;
    endfunction
endpackage

// File: rtl/cfgt_spi_port.sv
module cfgt_spi_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       frame_start,
    output logic       frame_end,
    output logic       rx_valid,
    output logic [7:0] rx_byte
);
    typedef struct packed {
        logic [2:0] sclk_s;
        logic [2:0] cs_s;
        logic [1:0] mosi_s;
        logic [2:0] bit_cnt;
        logic [6:0] rx_sh;
        logic [7:0] tx_sh;
        logic       rx_valid;
        logic [7:0] rx_byte;
    } port_t;

    port_t q, d;
    logic rise, fall, active;

    assign rise        = q.sclk_s[1] & ~q.sclk_s[2];
    assign fall        = ~q.sclk_s[1] & q.sclk_s[2];
    assign active      = ~q.cs_s[1];
    assign frame_start = q.cs_s[2] & ~q.cs_s[1];
    assign frame_end   = ~q.cs_s[2] & q.cs_s[1];

    always_comb begin
        d          = q;
        d.sclk_s   = {q.sclk_s[1:0], sclk};
        d.cs_s     = {q.cs_s[1:0], cs_n};
        d.mosi_s   = {q.mosi_s[0], mosi};
        d.rx_valid = 1'b0;
        if (frame_start) begin
            d.bit_cnt = '0;
            d.tx_sh   = '0;
        end else if (active && rise) begin
            d.bit_cnt = q.bit_cnt + 3'd1;
            d.rx_sh   = {q.rx_sh[5:0], q.mosi_s[1]};
            if (q.bit_cnt == 3'd7) begin
                d.rx_valid = 1'b1;
                d.rx_byte  = {q.rx_sh, q.mosi_s[1]};
                d.tx_sh    = tx_byte;
            end
        end else if (active && fall && q.bit_cnt != 3'd0) begin
            d.tx_sh = {q.tx_sh[6:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_s <= 3'b111;
        end else begin
            q <= d;
        end
    end

    assign miso     = q.tx_sh[7];
    assign rx_valid = q.rx_valid;
    assign rx_byte  = q.rx_byte;
endmodule

// File: rtl/cfgt_page_mem.sv
module cfgt_page_mem #(
    parameter int PAGES = 8,
    localparam int PG_W  = $clog2(PAGES),
    localparam int IDX_W = $clog2(PAGES * cfgt_pkg::PAGE_BYTES)
) (
    input  logic                                 clk,
    input  logic                                 we,
    input  logic [PG_W-1:0]                      waddr,
    input  logic [cfgt_pkg::PAGE_BYTES*8-1:0]    wdata,
    input  logic [IDX_W-1:0]                     raddr,
    output logic [7:0]                           rdata
);
    logic [cfgt_pkg::PAGE_BYTES*8-1:0] rows [PAGES];
    logic [cfgt_pkg::PAGE_BYTES*8-1:0] row;
    int unsigned                       k;

    always_ff @(posedge clk) begin
        if (we) rows[waddr] <= wdata;
    end

    always_comb begin
        row   = rows[raddr[IDX_W-1:4]];
        k     = 32'(raddr[3:0]);
        rdata = row[(15 - k) * 8 +: 8];
    end
endmodule

// File: rtl/cfgt_engine.sv
module cfgt_engine
    import cfgt_pkg::*;
#(
    parameter logic [31:0] ID_WORD        = 32'h1234_ABCD,
    parameter logic        DEV_VER        = 1'b1,
    parameter int          PAGES          = 8,
    parameter int          ERASE_CYCLES   = 5000,
    parameter int          REFRESH_CYCLES = 8000,
    localparam int PG_W  = $clog2(PAGES),
    localparam int TMR_W = $clog2((ERASE_CYCLES > REFRESH_CYCLES ? ERASE_CYCLES : REFRESH_CYCLES) + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_start,
    input  logic                    frame_end,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_byte,
    output logic [7:0]              tx_byte,
    output logic                    pg_we,
    output logic [PG_W-1:0]         pg_addr,
    output logic [PAGE_BYTES*8-1:0] pg_data,
    output logic                    done
);
    typedef struct packed {
        logic [4:0]              cnt;
        logic [7:0]              op;
        logic [7:0]              key;
        logic [31:0]             resp;
        logic [PAGE_BYTES*8-1:0] buf_w;
        logic                    loading;
        logic [PG_W-1:0]         addr;
        logic [PG_W-1:0]         wr_addr;
        logic                    we;
        logic                    enable;
        logic                    done;
        logic                    busy;
        logic                    fail;
        logic [2:0]              err;
        logic [TMR_W-1:0]        timer;
        wait_kind_e              kind;
    } eng_t;

    eng_t        q, d;
    logic [31:0] status_w, resp_now;

    always_comb begin
        status_w = pack_status(DEV_VER, q.err, q.fail, q.busy, q.enable, q.done);
        resp_now = (q.op == OP_READ_ID) ? ID_WORD : (q.op == OP_STATUS) ? status_w : 32'd0;
        case (q.cnt)
            5'd3:    tx_byte = resp_now[31:24];
            5'd4:    tx_byte = q.resp[23:16];
            5'd5:    tx_byte = q.resp[15:8];
            5'd6:    tx_byte = q.resp[7:0];
            default: tx_byte = 8'h00;
        endcase
    end

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (q.busy) begin
            if (q.timer == TMR_W'(1)) begin
                d.busy = 1'b0;
                if (q.kind == WAIT_ERASE) begin
                    d.done = 1'b0;
                    d.addr = '0;
                end else begin
                    d.enable = 1'b0;
                end
            end else begin
                d.timer = q.timer - TMR_W'(1);
            end
        end
        if (rx_valid) begin
            d.cnt = (q.cnt == 5'd31) ? q.cnt : q.cnt + 5'd1;
            if (q.cnt == 5'd0) d.op = rx_byte;
            else if (q.cnt == 5'd1) d.key = rx_byte;
            else if (q.cnt == 5'd3) begin
                d.resp = resp_now;
                case (q.op)
                    OP_READ_ID, OP_STATUS: ;
                    OP_ENABLE: begin
                        if (q.key == ENABLE_KEY) begin
                            d.enable = 1'b1;
                            d.fail   = 1'b0;
                            d.err    = ERR_NONE;
                        end else begin
                            d.err = ERR_CMD;
                        end
                    end
                    OP_ERASE: begin
                        d.busy  = 1'b1;
                        d.kind  = WAIT_ERASE;
                        d.timer = TMR_W'(ERASE_CYCLES);
                    end
                    OP_REFRESH: begin
                        d.busy  = 1'b1;
                        d.kind  = WAIT_REFRESH;
                        d.timer = TMR_W'(REFRESH_CYCLES);
                    end
                    OP_ADDR_CLR: d.addr = '0;
                    OP_FINISH, OP_PAGE: begin
                        if (!q.enable) begin
                            d.err  = ERR_CMD;
                            d.fail = 1'b1;
                        end else if (q.op == OP_PAGE) begin
                            d.loading = 1'b1;
                        end else begin
                            d.done = 1'b1;
                            d.err  = ERR_NONE;
                        end
                    end
                    default: d.err = ERR_CMD;
                endcase
            end else if (q.loading && q.cnt < 5'd20) begin
                d.buf_w = {q.buf_w[PAGE_BYTES*8-9:0], rx_byte};
            end
        end
        if (frame_end && q.loading) begin
            d.loading = 1'b0;
            if (q.cnt == 5'd20) begin
                d.we      = 1'b1;
                d.wr_addr = q.addr;
                d.addr    = (q.addr == PG_W'(PAGES - 1)) ? '0 : q.addr + PG_W'(1);
            end else begin
                d.err = ERR_OVFL;
            end
        end
        if (frame_start) begin
            d.cnt     = '0;
            d.loading = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pg_we   = q.we;
    assign pg_addr = q.wr_addr;
    assign pg_data = q.buf_w;
    assign done    = q.done;

    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.timer > TMR_W'(1)) |=> q.busy);
    assert_write_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> q.enable);
    assert_fail_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.fail) |-> q.err == ERR_CMD);
    assert_done_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> q.err == ERR_NONE);
    assert_enable_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.enable) |-> $past(q.busy));
endmodule

// File: rtl/cfgt_target.sv
module cfgt_target #(
    parameter logic [31:0] ID_WORD        = 32'h1234_ABCD,
    parameter logic        DEV_VER        = 1'b1,
    parameter int          PAGES          = 8,
    parameter int          ERASE_CYCLES   = 5000,
    parameter int          REFRESH_CYCLES = 8000,
    localparam int PG_W  = $clog2(PAGES),
    localparam int IDX_W = $clog2(PAGES * cfgt_pkg::PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             mosi,
    output logic             miso,
    input  logic [IDX_W-1:0] dbg_addr,
    output logic [7:0]       dbg_data,
    output logic             done
);
    logic       f_start, f_end, rx_v;
    logic [7:0] rx_b, tx_b;
    logic       we;
    logic [PG_W-1:0] waddr;
    logic [cfgt_pkg::PAGE_BYTES*8-1:0] wdata;

    cfgt_spi_port u_port (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .tx_byte(tx_b), .miso(miso), .frame_start(f_start), .frame_end(f_end),
        .rx_valid(rx_v), .rx_byte(rx_b)
    );

    cfgt_engine #(
        .ID_WORD(ID_WORD), .DEV_VER(DEV_VER), .PAGES(PAGES),
        .ERASE_CYCLES(ERASE_CYCLES), .REFRESH_CYCLES(REFRESH_CYCLES)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .frame_start(f_start), .frame_end(f_end),
        .rx_valid(rx_v), .rx_byte(rx_b), .tx_byte(tx_b), .pg_we(we),
        .pg_addr(waddr), .pg_data(wdata), .done(done)
    );

    cfgt_page_mem #(.PAGES(PAGES)) u_mem (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(dbg_addr), .rdata(dbg_data)
    );
endmodule

// File: tb/tb_cfgt_target.sv
module tb_cfgt_target;
    localparam logic [31:0] IDW = 32'hA5C3_1F07;
    localparam int PAGES = 4;
    localparam int ERASE = 1500;
    localparam int REFR  = 2500;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, done;
    logic [5:0] dbg_addr = '0;
    logic [7:0] dbg_data;
    logic [7:0] txb [24];
    logic [31:0] rdw;
    int tests = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cfgt_target #(.ID_WORD(IDW), .DEV_VER(1'b1), .PAGES(PAGES),
                  .ERASE_CYCLES(ERASE), .REFRESH_CYCLES(REFR)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .dbg_addr(dbg_addr), .dbg_data(dbg_data), .done(done));

    function automatic logic [31:0] st(input int err, input bit fl, input bit bs,
                                       input bit en, input bit dn);
        logic [31:0] w = 32'h0800_0000;
        w = w | (32'(err) << 23) | (32'(fl) << 13) | (32'(bs) << 12)
              | (32'(en) << 9) | (32'(dn) << 8);
        return w;
    endfunction

    function automatic logic [7:0] pat(input int p, input int k);
        return 8'((p * 37 + k * 11 + 3) & 255);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input int n);
        logic [7:0] b;
        rdw  = '0;
        cs_n = 1'b0;
        #40;
        for (int i = 0; i < n; i++) begin
            b = '0;
            for (int j = 7; j >= 0; j--) begin
                mosi = txb[i][j];
                #40;
                b = {b[6:0], miso};
                sclk = 1'b1;
                #40;
                sclk = 1'b0;
            end
            if (i >= 4 && i < 8) rdw = {rdw[23:0], b};
        end
        #40;
        cs_n = 1'b1;
        #100;
    endtask

    task automatic cmd(input logic [7:0] op, input logic [7:0] key, input int n);
        for (int i = 0; i < 24; i++) txb[i] = 8'h00;
        txb[0] = op;
        txb[1] = key;
        xfer(n);
    endtask

    task automatic page(input int p, input int ndata);
        for (int i = 0; i < 24; i++) txb[i] = 8'h00;
        txb[0] = 8'h70;
        txb[3] = 8'h01;
        for (int k = 0; k < ndata; k++) txb[4 + k] = pat(p, k);
        xfer(4 + ndata);
    endtask

    task automatic status(input string req, input logic [31:0] exp);
        cmd(8'h3C, 8'h00, 8);
        chk(req, rdw, exp);
    endtask

    task automatic chk_page(input string req, input int slot, input int p);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            dbg_addr = 6'(slot * 16 + k);
            #1;
            chk(req, {24'h0, dbg_data}, {24'h0, pat(p, k)});
        end
    endtask

    initial begin
        #(190000 * 5);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 done pin", {31'h0, done}, 32'h0);
        status("R1 reset status", st(0, 0, 0, 0, 0));
        cmd(8'hE0, 8'h00, 8);
        chk("R2 read id", rdw, IDW);
        // R3 wrong key
        cmd(8'hC6, 8'h00, 4);
        status("R3 bad key", st(2, 0, 0, 0, 0));
        // R7 finish and page while disabled
        cmd(8'h5E, 8'h00, 4);
        status("R7 finish disabled", st(2, 1, 0, 0, 0));
        page(7, 16);
        status("R7 page disabled", st(2, 1, 0, 0, 0));
        cmd(8'hC6, 8'h08, 4);
        status("R3 enable", st(0, 0, 0, 1, 0));
        // R11 unknown opcode
        cmd(8'hAB, 8'h08, 4);
        status("R11 unknown", st(2, 0, 0, 1, 0));
        cmd(8'hC6, 8'h08, 4);
        // R12 frames too short to act
        cmd(8'h0E, 8'h00, 2);
        cmd(8'h79, 8'h00, 3);
        status("R12 short frames", st(0, 0, 0, 1, 0));
        repeat (REFR + 200) @(posedge clk);
        status("R12 no late effect", st(0, 0, 0, 1, 0));
        // R4 erase window
        cmd(8'h0E, 8'h00, 4);
        status("R4 erase busy", st(0, 0, 1, 1, 0));
        repeat (1200) @(posedge clk);
        status("R4 erase over", st(0, 0, 0, 1, 0));
        // R5 five loads wrap over four pages
        for (int p = 0; p < 5; p++) page(p, 16);
        chk_page("R5 slot0 wrapped", 0, 4);
        for (int s = 1; s < PAGES; s++) chk_page("R5 slot", s, s);
        status("R5 clean status", st(0, 0, 0, 1, 0));
        // R6 short load at address 1
        page(8, 10);
        status("R6 overflow", st(6, 0, 0, 1, 0));
        chk_page("R6 untouched", 1, 1);
        page(9, 16);
        chk_page("R6 address kept", 1, 9);
        // R9 address clear
        cmd(8'h46, 8'h00, 4);
        page(11, 16);
        chk_page("R9 slot0", 0, 11);
        chk_page("R9 slot2 kept", 2, 2);
        // R8 finish
        cmd(8'h5E, 8'h00, 4);
        @(negedge clk);
        chk("R8 done pin", {31'h0, done}, 32'h1);
        status("R8 finish", st(0, 0, 0, 1, 1));
        // R10 refresh
        cmd(8'h79, 8'h00, 4);
        status("R10 refresh busy", st(0, 0, 1, 1, 1));
        repeat (REFR) @(posedge clk);
        status("R10 refresh over", st(0, 0, 0, 0, 1));
        @(negedge clk);
        chk("R10 done pin kept", {31'h0, done}, 32'h1);
        // R4 erase clears done
        cmd(8'hC6, 8'h08, 4);
        cmd(8'h0E, 8'h00, 4);
        repeat (ERASE + 200) @(posedge clk);
        status("R4 done cleared", st(0, 0, 0, 1, 0));
        @(negedge clk);
        chk("R4 done pin", {31'h0, done}, 32'h0);
        page(12, 16);
        chk_page("R4 address zero", 0, 12);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule